// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a countdown timer that belongs to a single processor. It lives in a 4 KB register page reached over a simple synchronous register bus. Software sets three things: the interrupt vector, the mask and the mode in a vector/control register, the clock divide ratio in a divider register, and the start value in an initial-count register. The current count can be read back at any time.

The counter steps down once every N bus clocks, where N is the programmed divide ratio. When it steps from one to zero, the block raises a level request on its local interrupt output and presents the 8-bit vector alongside it, unless the interrupt is masked. A periodic timer reloads its initial count and carries on. A one-shot timer stops at zero. The request and the busy flag in the vector/control register stay set until the processor pulses the acknowledge input.

Top module: `local_tick_timer`

## Requirements
- R1: A register is selected only when `addr_i[3:0]` is zero. The 16-byte slots are: vector/control at 0x320, initial count at 0x380, current count at 0x390 and divider at 0x3E0. Reads of any other address, including a misaligned one, return zero, and writes to them change no register.
- R2: Layout of the vector/control register: vector in bits 7:0, busy in bit 12, mask in bit 16 and periodic mode in bit 17. All other bits read as zero. After reset it reads 0x0001_0000 (masked, one-shot, vector 0). `vec_o` always shows the stored vector.
- R3: A write to the initial count stores the value and loads it into the current count. The prescaler phase restarts, so the first decrement comes N cycles after the write edge. Writing zero stops the timer, and no interrupt follows.
- R4: The divider code is {bit3, bit1, bit0} of the divider register. Codes 0 to 6 select divide-by 2^(code+1), and code 7 selects divide-by 1. Only those three bits are stored, and all other bits read as zero. Reset code is 0.
- R5: On expiry a one-shot timer sets the current count to zero and holds it there until the next initial-count write.
- R6: On expiry a periodic timer reloads the initial count, so with ratio N and count C it raises a request every N*C cycles.
- R7: While the mask bit is 1, expiry does not raise the request, but counting and reloading go on.
- R8: An unmasked expiry sets `irq_o` and the busy bit in the next cycle. Both stay set until a cycle with `ack_i` high. If an expiry and an acknowledge fall in the same cycle, the expiry wins.
- R9: The current-count register is read-only. Writes to it change neither the count nor the initial count.
- R10: Doubling the divide ratio while the initial count stays the same doubles the spacing between periodic requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the register page |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational, zero when not reading |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Local interrupt request level |
| vec_o | output | 8 | Vector delivered with the request |

## Verification
The bench builds the block with a 16-bit counter (CNT_W = 16) and keeps the default 32-bit data width. Because of this, truncation of wide initial-count writes is visible, and short counts at divide-by-1, 2 and 4 bring several periodic expiries within a few dozen cycles. Those expiries are enough to compare request spacing before and after a divider change. A behavioural model tracks count, phase, mask and request every clock. Read-backs then cover field packing, the read-only count and undecoded holes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned PAGE_W    = 12;
  localparam int unsigned SLOT_W    = PAGE_W - 4;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MAX_SHIFT = 7;
  localparam int unsigned PRESC_W   = MAX_SHIFT;
  localparam int unsigned SHIFT_W   = $clog2(MAX_SHIFT + 1);

  localparam logic [SLOT_W-1:0] SLOT_CTRL = 8'h32;
  localparam logic [SLOT_W-1:0] SLOT_INIT = 8'h38;
  localparam logic [SLOT_W-1:0] SLOT_CUR  = 8'h39;
  localparam logic [SLOT_W-1:0] SLOT_DIV  = 8'h3E;

  localparam int unsigned BUSY_BIT = 12;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned MODE_BIT = 17;

  typedef struct packed {
    logic       periodic;
    logic       mask;
    logic [7:0] vec;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{periodic: 1'b0, mask: 1'b1, vec: 8'h00};

  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    if (code == {CODE_W{1'b1}}) return '0;
    return SHIFT_W'(code) + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cur_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [CODE_W-1:0] code_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              aligned, wr, rd;
  logic [SLOT_W-1:0] slot;
  logic              wr_ctrl, wr_init, wr_div;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  init_q;
  logic [CODE_W-1:0] code_q;

  assign aligned = (addr_i[3:0] == 4'h0);
  assign slot    = addr_i[PAGE_W-1:4];
  assign wr      = sel_i && we_i && aligned;
  assign rd      = sel_i && !we_i && aligned;
  assign wr_ctrl = wr && (slot == SLOT_CTRL);
  assign wr_init = wr && (slot == SLOT_INIT);
  assign wr_div  = wr && (slot == SLOT_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      init_q <= '0;
      code_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.vec      <= wdata_i[7:0];
        ctrl_q.mask     <= wdata_i[MASK_BIT];
        ctrl_q.periodic <= wdata_i[MODE_BIT];
      end
      if (wr_init) init_q <= wdata_i[CNT_W-1:0];
      if (wr_div)  code_q <= {wdata_i[3], wdata_i[1], wdata_i[0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (slot)
        SLOT_CTRL: begin
          rdata_o[7:0]     = ctrl_q.vec;
          rdata_o[BUSY_BIT] = busy_i;
          rdata_o[MASK_BIT] = ctrl_q.mask;
          rdata_o[MODE_BIT] = ctrl_q.periodic;
        end
        SLOT_INIT: rdata_o[CNT_W-1:0] = init_q;
        SLOT_CUR:  rdata_o[CNT_W-1:0] = cur_i;
        SLOT_DIV: begin
          rdata_o[3] = code_q[2];
          rdata_o[1] = code_q[1];
          rdata_o[0] = code_q[0];
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign init_o     = init_q;
  assign code_o     = code_q;
  assign load_o     = wr_init;
  assign load_val_o = wdata_i[CNT_W-1:0];

  // R9
  cur_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && aligned && slot == SLOT_CUR) |=> init_q == $past(init_q));
  // R1
  hole_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !aligned) |=> (ctrl_q == $past(ctrl_q) && code_q == $past(code_q)));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tick_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W-1:0] phase_mask;

  // Ratio is a power of two, so a tick is the low bits of a free counter all set.
  assign phase_mask = PRESC_W'((1 << code_to_shift(code_i)) - 1);
  assign tick_o     = ((presc_q & phase_mask) == phase_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        presc_q <= '0;
    else if (restart_i) presc_q <= '0;
    else                presc_q <= presc_q + PRESC_W'(1);
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && code_i != {CODE_W{1'b1}} && !restart_i) |=> (!tick_o || code_i == {CODE_W{1'b1}}));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             mask_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_q;
  logic             irq_q;
  logic             expire;

  assign expire = tick_i && (cur_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (load_i) begin
      cur_q <= load_val_i;
    end else if (tick_i && cur_q != '0) begin
      if (cur_q == ONE) cur_q <= periodic_i ? init_i : '0;
      else              cur_q <= cur_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          irq_q <= 1'b0;
    else if (expire && !load_i && !mask_i) irq_q <= 1'b1;
    else if (ack_i)                       irq_q <= 1'b0;
  end

  assign cur_o = cur_q;
  assign irq_o = irq_q;

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_q == $past(load_val_i));
  // R5
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cur_q == '0) |=> cur_q == '0);
  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !load_i && periodic_i) |=> cur_q == $past(init_i));
  // R7
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && mask_i && !irq_q) |=> !irq_q);
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);
endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [7:0]        vec_o
);
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  init, load_val, cur;
  logic [CODE_W-1:0] code;
  logic              load, tick, irq;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i,
    .busy_i(irq), .cur_i(cur), .ctrl_o(ctrl), .init_o(init), .code_o(code),
    .load_o(load), .load_val_o(load_val), .rdata_o
  );

  tmr_prescale i_presc (
    .clk_i, .rst_ni, .restart_i(load), .code_i(code), .tick_o(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) i_count (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .init_i(init),
    .tick_i(tick), .periodic_i(ctrl.periodic), .mask_i(ctrl.mask), .ack_i,
    .cur_o(cur), .irq_o(irq)
  );

  assign irq_o = irq;
  assign vec_o = ctrl.vec;
endmodule

// File: tb/test_local_tick_timer.sv
`timescale 1ns/1ps
module test_local_tick_timer;
  localparam int CNT_W = 16;
  localparam logic [11:0] A_CTRL = 12'h320, A_INIT = 12'h380, A_CUR = 12'h390, A_DIV = 12'h3E0;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sel_i = 0, we_i = 0, ack_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic irq_o;
  logic [7:0] vec_o;

  always #2 clk = ~clk;

  local_tick_timer #(.DATA_W(32), .CNT_W(CNT_W)) i_local_tick_timer (
    .clk_i(clk), .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ack_i, .irq_o, .vec_o
  );

  int checks = 0, errors = 0, cyc = 0;
  int rises = 0, last_rise = 0, last_gap = 0;
  bit auto_ack = 0, irq_prev = 0, done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_cur, m_init, m_vec, m_mask, m_mode, m_code, m_irq, m_phase;
  int n_ratio, n_vec, n_mask, n_mode, n_code;
  bit t_tick, t_load, t_exp;

  function automatic int ratio(int code);
    return (code == 7) ? 1 : (2 << code);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cur = 0; m_init = 0; m_vec = 0; m_mask = 1; m_mode = 0;
      m_code = 0; m_irq = 0; m_phase = 0;
    end else begin
      n_ratio = ratio(m_code);
      t_tick = (m_phase % n_ratio) == n_ratio - 1;
      t_load = 0;
      n_vec = m_vec; n_mask = m_mask; n_mode = m_mode; n_code = m_code;
      if (sel_i && we_i && addr_i[3:0] == 0) begin
        case (addr_i)
          A_CTRL: begin n_vec = wdata_i[7:0]; n_mask = wdata_i[16]; n_mode = wdata_i[17]; end
          A_INIT: t_load = 1;
          A_DIV:  n_code = {wdata_i[3], wdata_i[1], wdata_i[0]};
          default: ;
        endcase
      end
      t_exp = t_tick && m_cur == 1 && !t_load;
      if (t_exp && !m_mask) m_irq = 1;
      else if (ack_i) m_irq = 0;
      if (t_load) begin
        m_cur = wdata_i & 32'hFFFF; m_init = m_cur;
      end else if (t_tick && m_cur != 0) begin
        m_cur = (m_cur == 1) ? (m_mode ? m_init : 0) : m_cur - 1;
      end
      m_phase = t_load ? 0 : m_phase + 1;
      m_vec = n_vec; m_mask = n_mask; m_mode = n_mode; m_code = n_code;
    end
  end

  // per-clock comparison and acknowledge driver
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      cyc++;
      chk("R8 irq", {31'b0, irq_o}, m_irq[31:0]);
      chk("R2 vec", {24'b0, vec_o}, m_vec[31:0]);
      if (irq_o && !irq_prev) begin
        rises++; last_gap = cyc - last_rise; last_rise = cyc;
      end
      irq_prev = irq_o;
      ack_i <= auto_ack && irq_o && !ack_i;
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); sel_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk); sel_i = 1; we_i = 0; addr_i = a;
    #1 chk(req, rdata_o, exp);
    sel_i = 0;
  endtask

  task automatic rd_cur(string req);
    @(negedge clk); sel_i = 1; we_i = 0; addr_i = A_CUR;
    #1 chk(req, rdata_o, m_cur[31:0]);
    sel_i = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int saved;
  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // reset state
    rd(A_CTRL, 32'h0001_0000, "R2 reset ctrl");
    rd(A_INIT, 0, "R1 reset init");
    rd(A_CUR,  0, "R1 reset cur");
    rd(A_DIV,  0, "R4 reset div");
    chk("R8 reset irq", {31'b0, irq_o}, 0);

    // field packing
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h0003_00FF, "R2 ctrl all ones");
    wr(A_CTRL, 32'h0000_0041);
    rd(A_CTRL, 32'h0000_0041, "R2 ctrl vec");
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, 32'h0000_000B, "R4 div all ones");
    wr(A_DIV, 32'h0000_0004);
    rd(A_DIV, 0, "R4 div bit2 ignored");

    // holes
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, 0, "R1 undecoded read");
    wr(12'h324, 32'h0003_00AA);
    rd(12'h324, 0, "R1 misaligned read");
    rd(A_CTRL, 32'h0000_0041, "R1 ctrl untouched");

    // one-shot at divide-by-1, truncated count
    wr(A_DIV, 32'h0000_000B);
    wr(A_INIT, 32'h0005_0005);
    rd(A_INIT, 32'h0000_0005, "R3 init truncated");
    rd_cur("R3 counting");
    wait_irq();
    rd(A_CUR, 0, "R5 oneshot zero");
    rd(A_CTRL, 32'h0000_1041, "R8 busy set");
    repeat (10) @(negedge clk);
    chk("R8 irq held", {31'b0, irq_o}, 1);
    auto_ack = 1;
    repeat (3) @(negedge clk);
    chk("R8 irq cleared", {31'b0, irq_o}, 0);
    rd(A_CTRL, 32'h0000_0041, "R8 busy cleared");
    rd(A_CUR, 0, "R5 holds zero");

    // read-only count
    wr(A_CUR, 32'h0000_0077);
    rd(A_CUR, 0, "R9 cur unchanged");
    rd(A_INIT, 32'h0000_0005, "R9 init unchanged");

    // periodic, divide-by-2 then 4
    wr(A_DIV, 32'h0000_0000);
    wr(A_CTRL, 32'h0002_0055);
    wr(A_INIT, 4);
    repeat (40) @(negedge clk);
    chk("R6 period div2", last_gap, 8);
    rd_cur("R6 counting");
    wr(A_DIV, 32'h0000_0001);
    repeat (70) @(negedge clk);
    chk("R10 period div4", last_gap, 16);

    // mask
    wr(A_CTRL, 32'h0003_0055);
    repeat (3) @(negedge clk);
    saved = rises;
    repeat (64) @(negedge clk);
    chk("R7 masked no irq", rises, saved);
    rd_cur("R7 still counting");

    // stop with zero
    wr(A_CTRL, 32'h0002_0055);
    wr(A_INIT, 0);
    saved = rises;
    repeat (64) @(negedge clk);
    chk("R3 stopped no irq", rises, saved);
    rd(A_CUR, 0, "R3 stopped count");

    // restart from stop
    wr(A_DIV, 32'h0000_000B);
    wr(A_INIT, 3);
    wait_irq();
    chk("R3 restart irq", {31'b0, irq_o}, 1);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule